// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Controller

This block turns the two switch commands of one half bridge into a high-side and a low-side gate enable. The high-side command is active low and the low-side command is active high. An unconnected command pin therefore reads as "off" on both sides. Both commands pass through a two-stage synchronizer before any decision is made. Turning a switch off takes effect on the next decision clock. Turning a switch on waits a programmable number of clock cycles after the opposite enable has dropped.

A mode input selects between two behaviours. In protected mode, shoot-through is blocked, and a request for both switches leaves the enables as they were. In overlap mode there is no dead time, and both switches may conduct at once, as a valve or injector load needs. A force-off input from the fault or disable logic clears both enables, whatever the commands are. Each half bridge uses its own instance, so two bridges run independently of each other.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset with `hs_cmd_n`=1 and `ls_cmd`=0, both `hs_en` and `ls_en` are 0. A low `hs_cmd_n` requests the high side and a high `ls_cmd` requests the low side.
- R2: A command change at the pins is decided on the third rising clock edge after it is applied: two edges for the synchronizer, one for the output register. No output reacts earlier.
- R3: In protected mode, an enable whose request is withdrawn drops on that decision edge, with no extra delay.
- R4: In protected mode, with steady commands, an enable rises only after the opposite enable has been low for exactly `dt_cycles`+1 sampled cycles. This holds in both directions, and `dt_cycles`=0 gives one such cycle.
- R5: In protected mode, two enables that are not both high never become both high. A request for both switches (`hs_cmd_n`=0, `ls_cmd`=1) keeps both enables at their present values.
- R6: In overlap mode (`allow_overlap`=1), each enable follows its own synchronized request with no dead time, so both may be high together.
- R7: `force_off`=1 clears both enables on the next edge and holds them low in either mode. After release with a steady single request, the requested enable rises on the (`dt_cycles`+1)-th edge.
- R8: A synchronized command change that arrives during a dead-time countdown reloads the count with the full `dt_cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decision clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd_n | input | 1 | High-side request, active low, asynchronous |
| ls_cmd | input | 1 | Low-side request, active high, asynchronous |
| allow_overlap | input | 1 | 1 = overlap mode, 0 = protected mode |
| dt_cycles | input | DT_W | Dead time in clock cycles |
| force_off | input | 1 | Clears both enables |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench measures the off gap between one enable falling and the other rising, in both directions and for several counts including zero. A design that counts one cycle short, or that skips the reload, shows the wrong gap length. A both-on request is applied from the idle state, from each single-on state and from the both-on state left behind by overlap mode. A design that forces both enables off, or that picks one side, fails these cases. A command that reverses in the middle of a countdown must stretch the off time by the full reload, and a design that keeps counting turns the enable on early. Force-off release timing and the three-edge input latency are also pinned down, which catches a missing or extra synchronizer stage.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_HS   = 2'b01,
    REQ_LS   = 2'b10,
    REQ_BOTH = 2'b11
  } hb_req_e;

  // Pin polarity: high side asserted low, low side asserted high.
  function automatic hb_req_e decode_req(input logic hs_n, input logic ls);
    return hb_req_e'({ls, ~hs_n});
  endfunction

  function automatic logic req_wants_hs(input hb_req_e r);
    return r[0];
  endfunction

  function automatic logic req_wants_ls(input hb_req_e r);
    return r[1];
  endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned   W       = 2,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hbdt_gap_timer.sv
module hbdt_gap_timer #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] load_val,
  input  logic            run,
  output logic            expired
);

  logic [DT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= '0;
    else if (load)                 remain <= load_val;
    else if (run && remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/hbdt_gate_arbiter.sv
module hbdt_gate_arbiter
  import hbdt_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  hb_req_e         req,
  input  logic            req_chg,
  input  logic            allow_overlap,
  input  logic            force_off,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            hs_cur,
  input  logic            ls_cur,
  input  logic            gap_done,
  output logic            hs_nxt,
  output logic            ls_nxt,
  output logic            tmr_load,
  output logic [DT_W-1:0] tmr_val,
  output logic            tmr_run
);

  always_comb begin
    hs_nxt   = hs_cur;
    ls_nxt   = ls_cur;
    tmr_load = 1'b0;
    tmr_val  = dt_cycles;
    tmr_run  = 1'b0;

    if (force_off) begin
      hs_nxt   = 1'b0;
      ls_nxt   = 1'b0;
      tmr_load = 1'b1;
    end else if (allow_overlap) begin
      hs_nxt   = req_wants_hs(req);
      ls_nxt   = req_wants_ls(req);
      tmr_load = 1'b1;
      tmr_val  = '0;
    end else begin
      unique case (req)
        REQ_NONE: begin
          hs_nxt = 1'b0;
          ls_nxt = 1'b0;
          if (hs_cur || ls_cur) tmr_load = 1'b1;
          else                  tmr_run  = 1'b1;
        end
        REQ_BOTH: begin
          // hold present enables, timer frozen
        end
        REQ_HS: begin
          ls_nxt = 1'b0;
          if (ls_cur || req_chg) tmr_load = 1'b1;
          else if (!gap_done)    tmr_run  = 1'b1;
          else                   hs_nxt   = 1'b1;
        end
        REQ_LS: begin
          hs_nxt = 1'b0;
          if (hs_cur || req_chg) tmr_load = 1'b1;
          else if (!gap_done)    tmr_run  = 1'b1;
          else                   ls_nxt   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hbdt_pkg::*;
#(
  parameter int unsigned DT_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_cmd_n,
  input  logic            ls_cmd,
  input  logic            allow_overlap,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            force_off,
  output logic            hs_en,
  output logic            ls_en
);

  localparam logic [1:0] CMD_IDLE = 2'b01; // {ls_cmd, hs_cmd_n} when off

  logic [1:0]      cmd_sync;
  hb_req_e         req_now;
  hb_req_e         req_q;
  logic            req_chg;
  logic            want_hs;
  logic            want_ls;
  logic            gap_done;
  logic            hs_nxt, ls_nxt;
  logic            tmr_load, tmr_run;
  logic [DT_W-1:0] tmr_val;

  hbdt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(CMD_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ls_cmd, hs_cmd_n}),
    .q     (cmd_sync)
  );

  assign req_now = decode_req(cmd_sync[0], cmd_sync[1]);
  assign want_hs = req_wants_hs(req_now);
  assign want_ls = req_wants_ls(req_now);
  assign req_chg = (req_now != req_q);

  hbdt_gap_timer #(.DT_W(DT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (gap_done)
  );

  hbdt_gate_arbiter #(.DT_W(DT_W)) u_arb (
    .req           (req_now),
    .req_chg       (req_chg),
    .allow_overlap (allow_overlap),
    .force_off     (force_off),
    .dt_cycles     (dt_cycles),
    .hs_cur        (hs_en),
    .ls_cur        (ls_en),
    .gap_done      (gap_done),
    .hs_nxt        (hs_nxt),
    .ls_nxt        (ls_nxt),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .tmr_run       (tmr_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
      req_q <= REQ_NONE;
    end else begin
      hs_en <= hs_nxt;
      ls_en <= ls_nxt;
      req_q <= req_now;
    end
  end

endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker #(
  parameter int unsigned DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            allow_overlap,
  input logic            force_off,
  input logic [DT_W-1:0] dt_cycles,
  input logic            want_hs,
  input logic            want_ls,
  input logic            hs_en,
  input logic            ls_en
);

  localparam int unsigned RUN_W = DT_W + 1;

  logic [RUN_W-1:0] hs_low_run, ls_low_run;
  logic [RUN_W-1:0] need_gap;

  assign need_gap = {1'b0, dt_cycles} + RUN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_run <= '0;
      ls_low_run <= '0;
    end else begin
      if (hs_en)                   hs_low_run <= '0;
      else if (hs_low_run != '1)   hs_low_run <= hs_low_run + 1'b1;
      if (ls_en)                   ls_low_run <= '0;
      else if (ls_low_run != '1)   ls_low_run <= ls_low_run + 1'b1;
    end
  end

  a_r5_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_overlap && !(hs_en && ls_en)) |=> !(hs_en && ls_en));

  a_r5_both_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_overlap && !force_off && want_hs && want_ls) |=> ($stable(hs_en) && $stable(ls_en)));

  a_r7_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!hs_en && !ls_en));

  a_r3_hs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_overlap && !force_off && !want_hs) |=> !hs_en);

  a_r3_ls_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_overlap && !force_off && !want_ls) |=> !ls_en);

  a_r6_overlap_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_overlap && !force_off) |=> (hs_en == $past(want_hs) && ls_en == $past(want_ls)));

  a_r4_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) && !$past(allow_overlap) && $stable(dt_cycles)) |-> (ls_low_run >= need_gap));

  a_r4_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_en) && !$past(allow_overlap) && $stable(dt_cycles)) |-> (hs_low_run >= need_gap));

endmodule

bind hb_deadtime_ctrl hbdt_checker #(.DT_W(DT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .allow_overlap (allow_overlap),
  .force_off     (force_off),
  .dt_cycles     (dt_cycles),
  .want_hs       (want_hs),
  .want_ls       (want_ls),
  .hs_en         (hs_en),
  .ls_en         (ls_en)
);

// File: tb/sim_hb_deadtime_ctrl.sv
module sim_hb_deadtime_ctrl;

  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hs_cmd_n = 1'b1;
  logic            ls_cmd = 1'b0;
  logic            allow_overlap = 1'b0;
  logic [DT_W-1:0] dt_cycles = 8'd2;
  logic            force_off = 1'b0;
  logic            hs_en, ls_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  hb_deadtime_ctrl #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd),
    .allow_overlap(allow_overlap), .dt_cycles(dt_cycles), .force_off(force_off),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  // {allow_overlap, hs_cmd_n, ls_cmd, exp_hs, exp_ls}, applied in order, dt = 2
  localparam logic [4:0] VEC [15] = '{
    5'b0_10_00, 5'b0_00_10, 5'b0_01_10, 5'b0_11_01, 5'b0_01_01,
    5'b0_10_00, 5'b0_01_00, 5'b1_01_11, 5'b1_10_00, 5'b1_00_10,
    5'b0_01_10, 5'b0_11_01, 5'b1_01_11, 5'b0_01_11, 5'b0_10_00
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_n(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic hn, input logic l);
    hs_cmd_n = hn;
    ls_cmd   = l;
  endtask

  // Dead-time gap from one side to the other, protected mode.
  task automatic gap_test(input int dt, input bit to_ls);
    int n;
    int guard;
    dt_cycles = DT_W'(dt);
    allow_overlap = 1'b0;
    if (to_ls) drive(1'b0, 1'b0); else drive(1'b1, 1'b1);
    step(30);
    if (to_ls) drive(1'b1, 1'b1); else drive(1'b0, 1'b0);
    guard = 0;
    while ((to_ls ? hs_en : ls_en) && guard < 50) begin step(1); guard++; end
    n = 0;
    while (!(to_ls ? ls_en : hs_en) && n < 600) begin n++; step(1); end
    check_n("R4", to_ls ? "hs->ls off gap" : "ls->hs off gap", n, dt + 1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    int n;
    bit saw_ls;
    // R1: reset holds enables low even with both requested
    drive(1'b0, 1'b1);
    step(4);
    check("R1", "enables in reset", {hs_en, ls_en}, 2'b00);
    drive(1'b1, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(6);
    check("R1", "idle after reset", {hs_en, ls_en}, 2'b00);

    // Vector table: steady-state results (R5, R6, R3, R4)
    for (int i = 0; i < 15; i++) begin
      allow_overlap = VEC[i][4];
      drive(VEC[i][3], VEC[i][2]);
      step(14);
      check(VEC[i][4] ? "R6" : "R5", $sformatf("vector %0d", i), {hs_en, ls_en}, VEC[i][1:0]);
    end

    // R2: three-edge latency in overlap mode
    allow_overlap = 1'b1;
    drive(1'b1, 1'b0);
    step(10);
    drive(1'b0, 1'b0);
    step(1); check("R2", "edge 1", {hs_en, ls_en}, 2'b00);
    step(1); check("R2", "edge 2", {hs_en, ls_en}, 2'b00);
    step(1); check("R2", "edge 3", {hs_en, ls_en}, 2'b10);
    // R6: swap sides in one decision, no gap
    drive(1'b1, 1'b1);
    step(3); check("R6", "swap without gap", {hs_en, ls_en}, 2'b01);

    // R3: protected turn-off lands on the decision edge
    allow_overlap = 1'b0;
    drive(1'b0, 1'b0);
    step(20);
    drive(1'b1, 1'b0);
    step(2); check("R3", "still on before decision", {hs_en, ls_en}, 2'b10);
    step(1); check("R3", "off at decision", {hs_en, ls_en}, 2'b00);

    // R4: gaps
    gap_test(0, 1'b1);
    gap_test(3, 1'b1);
    gap_test(7, 1'b1);
    gap_test(3, 1'b0);
    gap_test(0, 1'b0);

    // R7: force-off
    dt_cycles = 8'd4;
    allow_overlap = 1'b0;
    drive(1'b0, 1'b0);
    step(20);
    force_off = 1'b1;
    step(1); check("R7", "cleared next edge", {hs_en, ls_en}, 2'b00);
    step(6); check("R7", "held while forced", {hs_en, ls_en}, 2'b00);
    force_off = 1'b0;
    n = 0;
    step(1);
    while (!hs_en && n < 100) begin n++; step(1); end
    check_n("R7", "low edges after release", n, 4);
    allow_overlap = 1'b1;
    drive(1'b0, 1'b1);
    step(6);
    force_off = 1'b1;
    step(1); check("R7", "overlap mode forced", {hs_en, ls_en}, 2'b00);
    force_off = 1'b0;
    step(4);

    // R8: reversal during countdown reloads full dead time
    allow_overlap = 1'b0;
    dt_cycles = 8'd6;
    drive(1'b0, 1'b0);
    step(30);
    drive(1'b1, 1'b1);
    step(3);
    check("R8", "hs dropped", {hs_en, ls_en}, 2'b00);
    drive(1'b0, 1'b0);
    n = 0;
    saw_ls = 1'b0;
    while (!hs_en && n < 100) begin
      if (ls_en) saw_ls = 1'b1;
      n++;
      step(1);
    end
    check_n("R8", "hs off samples after reversal", n, 10);
    check_n("R8", "ls stayed off", int'(saw_ls), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule